// File: doc/BRIEF.md
# Multi-Lane TDM Audio Serializer

This block turns one frame of up to eight 32-bit audio channel words into time-division-multiplexed serial audio. It is a clock master: it makes its own bit clock and frame sync. Both are derived from a master-clock enable pulse that the surrounding clocking logic supplies. Up to four serial data lanes run in parallel. Each lane starts at a selectable channel pair and walks upward through the channels, one per slot, or it is tied to zero.

A configuration port captures the requested channel count, slot width, sample width, sync length, clock and sync polarity, a one-bit data delay, sample justification and the lane routing. An automatic routing option derives the lane sources from the channel request. The capture only happens while the serializer is stopped. A single enable starts the serializer, always at frame bit 0, and stops it. While stopped, every output rests at its idle level.

Top module: `tdm_serializer`

## Requirements
- R1: The channel request `cfg_chan_req` sets the frame length. A request of 0 to 2 gives 2 slots, 3 to 4 gives 4 slots, and anything larger gives 8 slots.
- R2: The slot code `cfg_slot_code` sets the bit clocks per slot: 0 gives 16, 1 gives 24, 2 or 3 gives 32.
- R3: Word-length code 2 selects 32-bit samples, and any other code selects 16-bit samples. A sample is the top bits of its 32-bit channel word and is sent MSB first. With `cfg_left`=1 the sample starts at slot bit 0. With `cfg_left`=0 it ends at the last slot bit. Slot bits outside the sample are 0, and a sample wider than its slot loses its top bits when right-justified and its bottom bits when left-justified.
- R4: The logical frame sync is high during frame bits 0 to `cfg_sync_len`, which is `cfg_sync_len`+1 bit clocks, and low for the rest of the frame.
- R5: Lane i takes its 3-bit source code from `cfg_lane_sel[3i+2:3i]`. A code p from 0 to 3 puts channel 2p+s on slot s, or 0 when 2p+s exceeds 7. A code of 4 or more makes the lane send zeros.
- R6: With `cfg_auto_route`=1, lane i uses code i if it is active and code 4 if it is not. A request of up to 2 channels activates lane 0. Up to 4 activates lanes 0-1. Up to 6 activates lanes 0-2. Anything larger activates all four lanes.
- R7: `cfg_bclk_inv` and `cfg_fsync_inv` each invert their output on their own. Data and sync change only on the logical falling edge of the bit clock and are steady at the logical rising edge.
- R8: With `cfg_delay`=1, every lane is one bit clock late relative to the sync. The first bit after start is 0.
- R9: `cfg_wr` captures the configuration only while `enable` is low and the serializer is stopped. A write at any other time has no effect.
- R10: When stopped, `sdata` is 0, `bclk` equals the stored clock inversion bit and `fsync` equals the stored sync inversion bit. Reset stores clock inversion 0 and sync inversion 0. After `enable` rises, the first bit clock carries frame bit 0, and `frame_strobe` pulses once at the start of each frame.
- R11: One bit-clock period lasts 2 x BCLK_HALF_TICKS cycles in which `mclk_en` is high. Cycles with `mclk_en` low do not advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mclk_en | input | 1 | Master-clock tick enable |
| enable | input | 1 | Run/stop control |
| cfg_wr | input | 1 | Configuration capture strobe |
| cfg_chan_req | input | 4 | Requested channel count |
| cfg_slot_code | input | 2 | Bit clocks per slot code |
| cfg_wlen_code | input | 2 | Sample width code |
| cfg_sync_len | input | 5 | Sync length minus one |
| cfg_bclk_inv | input | 1 | Bit clock inversion |
| cfg_fsync_inv | input | 1 | Frame sync inversion |
| cfg_delay | input | 1 | One-bit data delay |
| cfg_left | input | 1 | Left justification |
| cfg_auto_route | input | 1 | Derive lane routing from request |
| cfg_lane_sel | input | 12 | Manual 3-bit source code per lane |
| frame_data | input | 256 | Eight 32-bit channel words, channel c at bits 32c+31:32c |
| frame_strobe | output | 1 | Pulses when a frame's words are taken |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| sdata | output | 4 | Serial data lanes |

## Verification
On every cycle the assertions check four things: the captured configuration stays frozen while the serializer runs, a lane tied to zero stays low, data and sync hold still across each logical rising bit-clock edge, and a stop leaves all lanes quiet. They also check that each frame-start strobe coincides with an active sync. The exact bit stream needs the bench's scenarios: slot and sample alignment, the channel walk per lane, sync length, the delayed bit, the channel request mapping and the clock period with a gated master clock. The bench recovers these by sampling the lanes the way a receiver would, on each logical rising bit-clock edge, and compares the result with a model built from the requirements.

// File: rtl/tdm_ser_pkg.sv
package tdm_ser_pkg;
   localparam int NUM_CH    = 8;
   localparam int NUM_LANES = 4;
   localparam int WORD_W    = 32;
   localparam int SEL_W     = 3;
   localparam int SLOT_IW   = $clog2(NUM_CH);
   localparam int BIT_IW    = $clog2(WORD_W);
   localparam int FBIT_W    = $clog2(NUM_CH * WORD_W);

   typedef struct packed {
      logic [3:0]                          n_slots;
      logic [5:0]                          slot_bits;
      logic [5:0]                          word_bits;
      logic [4:0]                          sync_len;
      logic                                bclk_inv;
      logic                                fsync_inv;
      logic                                delay;
      logic                                left;
      logic [NUM_LANES-1:0][SEL_W-1:0]     lane_sel;
   } tdm_cfg_t;

   function automatic logic [3:0] slots_for_req(input logic [3:0] req);
      if (req <= 4'd2)      return 4'd2;
      else if (req <= 4'd4) return 4'd4;
      else                  return 4'd8;
   endfunction

   function automatic logic [2:0] lanes_for_req(input logic [3:0] req);
      if (req <= 4'd2)      return 3'd1;
      else if (req <= 4'd4) return 3'd2;
      else if (req <= 4'd6) return 3'd3;
      else                  return 3'd4;
   endfunction

   function automatic logic [5:0] bits_for_slot(input logic [1:0] code);
      case (code)
         2'd0:    return 6'd16;
         2'd1:    return 6'd24;
         default: return 6'd32;
      endcase
   endfunction

   function automatic logic [5:0] bits_for_word(input logic [1:0] code);
      return (code == 2'd2) ? 6'd32 : 6'd16;
   endfunction
endpackage

// File: rtl/tdm_ser_cfg.sv
module tdm_ser_cfg
   import tdm_ser_pkg::*;
(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr,
   input  logic                        enable,
   input  logic                        running,
   input  logic [3:0]                  chan_req,
   input  logic [1:0]                  slot_code,
   input  logic [1:0]                  wlen_code,
   input  logic [4:0]                  sync_len,
   input  logic                        bclk_inv,
   input  logic                        fsync_inv,
   input  logic                        delay,
   input  logic                        left,
   input  logic                        auto_route,
   input  logic [NUM_LANES*SEL_W-1:0]  lane_sel,
   output tdm_cfg_t                    cfg_q
);
   localparam logic [SEL_W-1:0] ZERO_CODE = SEL_W'(4);

   tdm_cfg_t  decoded;
   tdm_cfg_t  reset_cfg;
   logic [2:0] act_lanes;

   always_comb begin
      act_lanes          = lanes_for_req(chan_req);
      decoded.n_slots    = slots_for_req(chan_req);
      decoded.slot_bits  = bits_for_slot(slot_code);
      decoded.word_bits  = bits_for_word(wlen_code);
      decoded.sync_len   = sync_len;
      decoded.bclk_inv   = bclk_inv;
      decoded.fsync_inv  = fsync_inv;
      decoded.delay      = delay;
      decoded.left       = left;
      for (int i = 0; i < NUM_LANES; i++) begin
         if (auto_route)
            decoded.lane_sel[i] = (3'(i) < act_lanes) ? SEL_W'(i) : ZERO_CODE;
         else
            decoded.lane_sel[i] = lane_sel[i*SEL_W +: SEL_W];
      end
   end

   always_comb begin
      reset_cfg.n_slots   = 4'd2;
      reset_cfg.slot_bits = 6'd16;
      reset_cfg.word_bits = 6'd16;
      reset_cfg.sync_len  = 5'd15;
      reset_cfg.bclk_inv  = 1'b0;
      reset_cfg.fsync_inv = 1'b0;
      reset_cfg.delay     = 1'b0;
      reset_cfg.left      = 1'b1;
      for (int i = 0; i < NUM_LANES; i++)
         reset_cfg.lane_sel[i] = (i == 0) ? '0 : ZERO_CODE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_q <= reset_cfg;
      else if (wr && !enable && !running)
         cfg_q <= decoded;
   end
endmodule

// File: rtl/tdm_ser_timer.sv
module tdm_ser_timer
   import tdm_ser_pkg::*;
#(
   parameter int HALF_TICKS = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               mclk_en,
   input  logic [3:0]         n_slots,
   input  logic [5:0]         slot_bits,
   output logic               running,
   output logic               phase,
   output logic               start,
   output logic               load,
   output logic [SLOT_IW-1:0] nxt_slot,
   output logic [BIT_IW-1:0]  nxt_bit,
   output logic [FBIT_W-1:0]  nxt_fbit
);
   localparam int DIV_W = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_TICKS - 1);

   logic [DIV_W-1:0]   div_q;
   logic [SLOT_IW-1:0] slot_q;
   logic [BIT_IW-1:0]  bit_q;
   logic [FBIT_W-1:0]  fbit_q;
   logic               half_done, fall, last_bit, last_slot;

   assign half_done = mclk_en && (div_q == DIV_LAST);
   assign start     = enable && !running;
   assign fall      = enable && running && half_done && phase;
   assign load      = start || fall;
   assign last_bit  = ({1'b0, bit_q} == (slot_bits - 6'd1));
   assign last_slot = ({1'b0, slot_q} == (n_slots - 4'd1));

   always_comb begin
      if (start) begin
         nxt_slot = '0;
         nxt_bit  = '0;
         nxt_fbit = '0;
      end else begin
         nxt_bit  = last_bit ? '0 : bit_q + 1'b1;
         nxt_slot = !last_bit ? slot_q : (last_slot ? '0 : slot_q + 1'b1);
         nxt_fbit = (last_bit && last_slot) ? '0 : fbit_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         phase   <= 1'b0;
         div_q   <= '0;
         slot_q  <= '0;
         bit_q   <= '0;
         fbit_q  <= '0;
      end else if (!enable) begin
         running <= 1'b0;
         phase   <= 1'b0;
         div_q   <= '0;
      end else if (!running) begin
         running <= 1'b1;
         phase   <= 1'b0;
         div_q   <= '0;
         slot_q  <= nxt_slot;
         bit_q   <= nxt_bit;
         fbit_q  <= nxt_fbit;
      end else if (mclk_en) begin
         if (half_done) begin
            div_q <= '0;
            phase <= ~phase;
            if (fall) begin
               slot_q <= nxt_slot;
               bit_q  <= nxt_bit;
               fbit_q <= nxt_fbit;
            end
         end else begin
            div_q <= div_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tdm_ser_lane.sv
module tdm_ser_lane
   import tdm_ser_pkg::*;
(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      load,
   input  logic [SEL_W-1:0]          sel,
   input  logic [SLOT_IW-1:0]        slot,
   input  logic [BIT_IW-1:0]         bitpos,
   input  logic [5:0]                slot_bits,
   input  logic [5:0]                word_bits,
   input  logic                      left,
   input  logic                      delay,
   input  logic [NUM_CH*WORD_W-1:0]  words,
   output logic                      bit_out
);
   logic [3:0]        ch;
   logic              ch_ok;
   logic [WORD_W-1:0] word;
   logic signed [7:0] idx;
   logic              in_word, nxt_bit;
   logic              cur_q, dly_q;

   always_comb begin
      ch    = {1'b0, sel[1:0], 1'b0} + {1'b0, slot};
      ch_ok = !sel[2] && !ch[3];
      word  = words[ch[2:0]*WORD_W +: WORD_W];
      if (left)
         idx = $signed({3'b0, bitpos});
      else
         idx = $signed({3'b0, bitpos}) - $signed({2'b0, slot_bits})
             + $signed({2'b0, word_bits});
      in_word = (idx >= 0) && (idx < $signed({2'b0, word_bits}));
      nxt_bit = ch_ok && in_word && word[5'd31 - idx[4:0]];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= 1'b0;
         dly_q <= 1'b0;
      end else if (start) begin
         cur_q <= nxt_bit;
         dly_q <= 1'b0;
      end else if (load) begin
         cur_q <= nxt_bit;
         dly_q <= cur_q;
      end
   end

   assign bit_out = delay ? dly_q : cur_q;
endmodule

// File: rtl/tdm_serializer.sv
module tdm_serializer
   import tdm_ser_pkg::*;
#(
   parameter int BCLK_HALF_TICKS = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        mclk_en,
   input  logic                        enable,
   input  logic                        cfg_wr,
   input  logic [3:0]                  cfg_chan_req,
   input  logic [1:0]                  cfg_slot_code,
   input  logic [1:0]                  cfg_wlen_code,
   input  logic [4:0]                  cfg_sync_len,
   input  logic                        cfg_bclk_inv,
   input  logic                        cfg_fsync_inv,
   input  logic                        cfg_delay,
   input  logic                        cfg_left,
   input  logic                        cfg_auto_route,
   input  logic [NUM_LANES*SEL_W-1:0]  cfg_lane_sel,
   input  logic [NUM_CH*WORD_W-1:0]    frame_data,
   output logic                        frame_strobe,
   output logic                        bclk,
   output logic                        fsync,
   output logic [NUM_LANES-1:0]        sdata
);
   generate
      if (BCLK_HALF_TICKS < 1) begin : g_bad_div
         $error("BCLK_HALF_TICKS must be at least 1");
      end
   endgenerate

   tdm_cfg_t           cfg_q;
   logic               running, phase, start, load, frame_first;
   logic [SLOT_IW-1:0] nxt_slot;
   logic [BIT_IW-1:0]  nxt_bit;
   logic [FBIT_W-1:0]  nxt_fbit;
   logic [NUM_CH*WORD_W-1:0] held_q, words;
   logic               fsync_q;
   logic [NUM_LANES-1:0] lane_bits;

   tdm_ser_cfg u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .enable(enable), .running(running),
      .chan_req(cfg_chan_req), .slot_code(cfg_slot_code), .wlen_code(cfg_wlen_code),
      .sync_len(cfg_sync_len), .bclk_inv(cfg_bclk_inv), .fsync_inv(cfg_fsync_inv),
      .delay(cfg_delay), .left(cfg_left), .auto_route(cfg_auto_route),
      .lane_sel(cfg_lane_sel), .cfg_q(cfg_q)
   );

   tdm_ser_timer #(.HALF_TICKS(BCLK_HALF_TICKS)) u_timer (
      .clk(clk), .rst_n(rst_n), .enable(enable), .mclk_en(mclk_en),
      .n_slots(cfg_q.n_slots), .slot_bits(cfg_q.slot_bits),
      .running(running), .phase(phase), .start(start), .load(load),
      .nxt_slot(nxt_slot), .nxt_bit(nxt_bit), .nxt_fbit(nxt_fbit)
   );

   assign frame_first = load && (nxt_fbit == '0);
   assign words       = frame_first ? frame_data : held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q       <= '0;
         fsync_q      <= 1'b0;
         frame_strobe <= 1'b0;
      end else begin
         frame_strobe <= frame_first;
         if (frame_first)
            held_q <= frame_data;
         if (load)
            fsync_q <= (nxt_fbit <= FBIT_W'(cfg_q.sync_len));
      end
   end

   generate
      for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
         tdm_ser_lane u_lane (
            .clk(clk), .rst_n(rst_n), .start(start), .load(load),
            .sel(cfg_q.lane_sel[g]), .slot(nxt_slot), .bitpos(nxt_bit),
            .slot_bits(cfg_q.slot_bits), .word_bits(cfg_q.word_bits),
            .left(cfg_q.left), .delay(cfg_q.delay), .words(words),
            .bit_out(lane_bits[g])
         );
      end
   endgenerate

   assign bclk  = running ? (phase ^ cfg_q.bclk_inv) : cfg_q.bclk_inv;
   assign fsync = running ? (fsync_q ^ cfg_q.fsync_inv) : cfg_q.fsync_inv;
   assign sdata = running ? lane_bits : '0;
endmodule

// File: rtl/tdm_serializer_chk.sv
module tdm_serializer_chk
   import tdm_ser_pkg::*;
(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 enable,
   input logic                 running,
   input tdm_cfg_t             cfg_q,
   input logic                 frame_strobe,
   input logic                 bclk,
   input logic                 fsync,
   input logic [NUM_LANES-1:0] sdata
);
   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      running && $past(running) |-> $stable(cfg_q)) else $error("cfg changed while running"); // R9

   AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !enable && $past(!enable) |-> sdata == '0) else $error("lanes active after stop"); // R10

   AST_EDGE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      running && $past(running) && $rose(bclk ^ cfg_q.bclk_inv)
      |-> $stable(sdata) && $stable(fsync)) else $error("data moved on rising edge"); // R7

   AST_STROBE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      running && frame_strobe |-> fsync != cfg_q.fsync_inv) else $error("frame start without sync"); // R4

   generate
      for (genvar g = 0; g < NUM_LANES; g++) begin : g_zero
         AST_ZERO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
            running && cfg_q.lane_sel[g][2] |-> !sdata[g]) else $error("zero lane driven"); // R5
      end
   endgenerate
endmodule

bind tdm_serializer tdm_serializer_chk u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .running(running), .cfg_q(cfg_q),
   .frame_strobe(frame_strobe), .bclk(bclk), .fsync(fsync), .sdata(sdata)
);

// File: tb/tb_tdm_serializer.sv
`timescale 1ns/1ps
module tb_tdm_serializer;
   typedef struct packed {
      logic [3:0]  req;
      logic [1:0]  slot;
      logic [1:0]  wl;
      logic [4:0]  sw;
      logic        bi, si, dl, lf, au;
      logic [11:0] ls;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{4'd2, 2'd0, 2'd1, 5'd15, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 12'h000},
      '{4'd4, 2'd2, 2'd2, 5'd31, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 12'h000},
      '{4'd6, 2'd1, 2'd1, 5'd0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 12'h000},
      '{4'd8, 2'd2, 2'd1, 5'd3,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 12'h000},
      '{4'd2, 2'd1, 2'd1, 5'd23, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 12'h000},
      '{4'd4, 2'd0, 2'd2, 5'd9,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, {3'd3, 3'd2, 3'd1, 3'd0}},
      '{4'd1, 2'd2, 2'd2, 5'd5,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, {3'd4, 3'd0, 3'd5, 3'd2}},
      '{4'd8, 2'd0, 2'd2, 5'd7,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, {3'd0, 3'd0, 3'd0, 3'd0}}
   };

   logic clk = 1'b0, rst_n = 1'b0, mclk_en = 1'b1, enable = 1'b0, cfg_wr = 1'b0;
   logic [3:0]  cfg_chan_req = '0;
   logic [1:0]  cfg_slot_code = '0, cfg_wlen_code = '0;
   logic [4:0]  cfg_sync_len = '0;
   logic        cfg_bclk_inv = 0, cfg_fsync_inv = 0, cfg_delay = 0, cfg_left = 0, cfg_auto_route = 0;
   logic [11:0] cfg_lane_sel = '0;
   logic [255:0] frame_data;
   logic        frame_strobe, bclk, fsync;
   logic [3:0]  sdata;
   int          n_checks = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   tdm_serializer dut (
      .clk(clk), .rst_n(rst_n), .mclk_en(mclk_en), .enable(enable), .cfg_wr(cfg_wr),
      .cfg_chan_req(cfg_chan_req), .cfg_slot_code(cfg_slot_code), .cfg_wlen_code(cfg_wlen_code),
      .cfg_sync_len(cfg_sync_len), .cfg_bclk_inv(cfg_bclk_inv), .cfg_fsync_inv(cfg_fsync_inv),
      .cfg_delay(cfg_delay), .cfg_left(cfg_left), .cfg_auto_route(cfg_auto_route),
      .cfg_lane_sel(cfg_lane_sel), .frame_data(frame_data), .frame_strobe(frame_strobe),
      .bclk(bclk), .fsync(fsync), .sdata(sdata)
   );

   function automatic logic [31:0] chan_word(int c);
      return 32'h9E37_79B9 * (c + 1) ^ 32'h0F0F_3C3C;
   endfunction

   function automatic int n_slots(vec_t v);
      return (v.req <= 2) ? 2 : (v.req <= 4) ? 4 : 8;
   endfunction
   function automatic int slot_w(vec_t v);
      return (v.slot == 0) ? 16 : (v.slot == 1) ? 24 : 32;
   endfunction
   function automatic int word_w(vec_t v);
      return (v.wl == 2) ? 32 : 16;
   endfunction
   function automatic int lane_code(vec_t v, int lane);
      int act;
      act = (v.req <= 2) ? 1 : (v.req <= 4) ? 2 : (v.req <= 6) ? 3 : 4;
      if (v.au) return (lane < act) ? lane : 4;
      return int'(v.ls[3*lane +: 3]);
   endfunction
   function automatic logic frame_bit(vec_t v, int lane, int p);
      int sw, wl, s, b, p2, ch, idx;
      logic [31:0] w;
      sw = slot_w(v); wl = word_w(v);
      s = p / sw; b = p % sw;
      p2 = lane_code(v, lane);
      if (p2 >= 4) return 1'b0;
      ch = 2 * p2 + s;
      if (ch > 7) return 1'b0;
      idx = v.lf ? b : b - (sw - wl);
      if (idx < 0 || idx >= wl) return 1'b0;
      w = chan_word(ch);
      return w[31 - idx];
   endfunction

   function automatic string vec_tag(int i);
      case (i)
         0: return "R1 R6 R10";
         1: return "R2 R3";
         2: return "R1 R4 R6";
         3: return "R7 R8";
         4: return "R3";
         5: return "R3 R5";
         6: return "R1 R5 R8";
         default: return "R3 R4";
      endcase
   endfunction

   task automatic check(input string tag, input logic ok, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input vec_t v);
      @(negedge clk);
      cfg_chan_req = v.req; cfg_slot_code = v.slot; cfg_wlen_code = v.wl;
      cfg_sync_len = v.sw; cfg_bclk_inv = v.bi; cfg_fsync_inv = v.si;
      cfg_delay = v.dl; cfg_left = v.lf; cfg_auto_route = v.au; cfg_lane_sel = v.ls;
      cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic capture_check(input vec_t v, input string tag);
      int fl, k, cyc, strobes, bad, first_k;
      logic prev_b, lb, ef, af;
      logic [3:0] ed;
      fl = n_slots(v) * slot_w(v);
      k = 0; cyc = 0; strobes = 0; bad = 0; first_k = -1;
      ed = '0; ef = 1'b0; af = 1'b0;
      @(negedge clk);
      enable = 1'b1;
      prev_b = bclk ^ v.bi;
      while (k < 2 * fl && cyc < 5000) begin
         @(negedge clk);
         cyc++;
         if (frame_strobe) strobes++;
         lb = bclk ^ v.bi;
         if (lb && !prev_b) begin
            for (int l = 0; l < 4; l++)
               ed[l] = v.dl ? ((k == 0) ? 1'b0 : frame_bit(v, l, (k - 1) % fl))
                            : frame_bit(v, l, k % fl);
            ef = ((k % fl) <= int'(v.sw));
            af = fsync ^ v.si;
            if (ed !== sdata || ef !== af) begin
               if (bad == 0) first_k = k;
               bad++;
            end
            k++;
         end
         prev_b = lb;
      end
      check({tag, " stream"}, bad == 0 && k == 2 * fl, first_k, k);
      check({tag, " R10 frame strobes"}, strobes == 2, strobes, 2);
      enable = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic measure_period(input logic slow, output int period);
      int r1, r2;
      logic prev_b, lb;
      r1 = -1; r2 = -1;
      @(negedge clk);
      enable = 1'b1;
      prev_b = bclk;
      for (int cyc = 0; cyc < 200 && r2 < 0; cyc++) begin
         mclk_en = slow ? logic'(cyc % 2) : 1'b1;
         @(negedge clk);
         lb = bclk;
         if (lb && !prev_b) begin
            if (r1 < 0) r1 = cyc; else r2 = cyc;
         end
         prev_b = lb;
      end
      period = r2 - r1;
      mclk_en = 1'b1;
      enable = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      int per;
      for (int c = 0; c < 8; c++) frame_data[c*32 +: 32] = chan_word(c);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R10 reset levels
      check("R10 reset idle", bclk == 0 && fsync == 0 && sdata == 0 && frame_strobe == 0,
            {frame_strobe, bclk, fsync, sdata}, 0);

      for (int i = 0; i < NV; i++) begin
         cfg_write(VECS[i]);
         capture_check(VECS[i], $sformatf("vector %0d %s", i, vec_tag(i)));
         if (i == 3) // R7 R10 idle levels follow the inversion bits
            check("R7 R10 inverted idle", bclk == 1 && fsync == 1 && sdata == 0,
                  {bclk, fsync, sdata}, 6'h30);
      end

      // R9: a write while running is ignored
      cfg_write(VECS[0]);
      @(negedge clk); enable = 1'b1;
      repeat (10) @(negedge clk);
      cfg_chan_req = VECS[3].req; cfg_slot_code = VECS[3].slot; cfg_bclk_inv = 1'b1;
      cfg_fsync_inv = 1'b1; cfg_delay = 1'b1; cfg_wr = 1'b1;
      @(negedge clk); cfg_wr = 1'b0;
      enable = 1'b0;
      repeat (3) @(negedge clk);
      capture_check(VECS[0], "R9 write while running");

      // R11 bit clock period
      measure_period(1'b0, per);
      check("R11 period full rate", per == 4, per, 4);
      measure_period(1'b1, per);
      check("R11 period gated", per == 8, per, 8);

      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule